// File: doc/BRIEF.md
# Fixed-Point Carry and Overflow Flag Generator

This block sits after a 64-bit integer datapath and turns the operands and result of one operation into the architectural status bits: carry (64-bit and 32-bit), overflow (64-bit and 32-bit), the sticky summary-overflow bit, and a 4-bit condition field for record forms. The arithmetic unit and the division overflow detector are outside the block. The division unit's verdict arrives as an input.

Carry is not taken from an adder carry-out. A carry is flagged when any participating operand is unsigned-greater than the result. For add-class operations the 32-bit carry uses an XOR rule on bit 32 instead. The operand list holds the first `num_ops` register operands, followed by the immediate when it is valid. The first register operand can be inverted before any flag is derived.

All updates are registered on one `valid` strobe. Flag groups whose enable is low keep their values. The instruction can mark flags it already wrote itself through `done_mask`. Those flags are then left untouched.

Top module: `fx_flag_unit`

## Requirements
- R1: While `rst_n` is low, all flag outputs and `cr0` are 0.
- R2: Outputs change only on a rising clock edge with `valid` high. A flag group whose enable (`carry_en`, `ov_en`, `rc_en`) is low keeps its value.
- R3: The operand list is `op_a`, `op_b`, `op_c`, restricted to the first `num_ops` (0..3) of them, followed by `imm` when `imm_vld` is 1. When `inv_a` is 1, `op_a` is bitwise inverted before any flag is derived.
- R4: With `carry_en`, `ca` becomes 1 when any listed operand is unsigned-greater than the 64-bit `result`, and 0 otherwise.
- R5: With `carry_en` and `is_add`, `ca32` becomes `result[32] ^ first[32] ^ second[32]`. Here first and second are the first two list entries, and a missing entry reads as 0.
- R6: With `carry_en` and not `is_add`, `ca32` becomes 1 when any listed operand's bits [31:0] are unsigned-greater than `result[31:0]`.
- R7: `done_mask[0]` = 1 leaves `ca` unchanged, and `done_mask[1]` = 1 leaves `ca32` unchanged.
- R8: With `ov_en`, no division indication, and at least two listed operands, `ov` is 1 when the first two operands share a sign (bit 63) and the result's bit 63 differs. `ov32` applies the same rule to bit 31. With fewer than two operands, both flags are held.
- R9: With `ov_en` and `div_ov_vld`, both `ov` and `ov32` take the value of `div_ov`.
- R10: Whenever the overflow flags are updated, `so` becomes `so | ov_new`. `so` is cleared only by reset.
- R11: With `rc_en`, `cr0` becomes {negative, positive, zero, so} in bits [3:0], MSB first. The sign test reads `result` as a signed 64-bit value, and the last bit is the `so` value after this update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| valid | input | 1 | Register the flag update this cycle |
| op_a | input | 64 | First register operand |
| op_b | input | 64 | Second register operand |
| op_c | input | 64 | Third register operand |
| num_ops | input | 2 | Number of register operands in use |
| imm | input | 64 | Immediate operand |
| imm_vld | input | 1 | Immediate is appended to the operand list |
| inv_a | input | 1 | Invert `op_a` before flag derivation |
| result | input | 64 | Result of the operation |
| is_add | input | 1 | Use the add rule for `ca32` |
| carry_en | input | 1 | Update carry flags |
| ov_en | input | 1 | Update overflow flags |
| rc_en | input | 1 | Update the condition field |
| done_mask | input | 2 | Bit 0 protects `ca`, bit 1 protects `ca32` |
| div_ov_vld | input | 1 | Division overflow verdict supplied |
| div_ov | input | 1 | Division overflow verdict |
| ca | output | 1 | Carry |
| ca32 | output | 1 | 32-bit carry |
| ov | output | 1 | Overflow |
| ov32 | output | 1 | 32-bit overflow |
| so | output | 1 | Sticky summary overflow |
| cr0 | output | 4 | {negative, positive, zero, so} |

## Verification
The checker watches properties that hold on every cycle:
- flags hold without `valid`;
- carries hold when `carry_en` is low or when the mask protects them;
- the division verdict is copied into both overflow bits;
- `so` never falls outside reset;
- a recorded `cr0` has exactly one sign bit set and its last bit matches `so`.

Only the bench's vectors can show the operand-dependent parts: the unsigned carry comparison, the add versus non-add `ca32` rules, inversion and immediate placement in the operand list, and that the overflow flags are skipped with a single operand.

// File: rtl/fxflag_pkg.sv
package fxflag_pkg;

    // Architectural status bits kept by the flag generator
    typedef struct packed {
        logic ca;
        logic ca32;
        logic ov;
        logic ov32;
        logic so;
    } xer_bits_t;

    // Condition field bit positions, MSB first
    localparam int CR_NEG  = 3;
    localparam int CR_POS  = 2;
    localparam int CR_ZERO = 1;
    localparam int CR_SO   = 0;

endpackage

// File: rtl/fxflag_opsel.sv
module fxflag_opsel #(
    parameter int DW   = 64,
    parameter int NREG = 3,
    localparam int CW  = $clog2(NREG + 1)
) (
    input  logic [DW-1:0] regs [NREG],
    input  logic [CW-1:0] num_ops,
    input  logic [DW-1:0] imm,
    input  logic          imm_vld,
    input  logic          inv_first,
    output logic [DW-1:0] ops      [NREG+1],
    output logic          ops_vld  [NREG+1],
    output logic [DW-1:0] first,
    output logic [DW-1:0] second,
    output logic          n_ge2
);
    // Register slots, first one optionally inverted
    for (genvar i = 0; i < NREG; i++) begin : g_slot
        if (i == 0) begin : g_inv
            assign ops[i] = inv_first ? ~regs[i] : regs[i];
        end else begin : g_pass
            assign ops[i] = regs[i];
        end
        assign ops_vld[i] = (CW'(i) < num_ops);
    end

    // Immediate occupies the final slot
    assign ops[NREG]     = imm;
    assign ops_vld[NREG] = imm_vld;

    always_comb begin
        first  = '0;
        second = '0;
        if (num_ops >= CW'(2)) begin
            first  = ops[0];
            second = ops[1];
        end else if (num_ops == CW'(1)) begin
            first  = ops[0];
            second = imm_vld ? imm : '0;
        end else begin
            first  = imm_vld ? imm : '0;
        end
    end

    assign n_ge2 = ({1'b0, num_ops} + (CW+1)'(imm_vld)) >= (CW+1)'(2);

endmodule

// File: rtl/fxflag_carry.sv
module fxflag_carry #(
    parameter int DW   = 64,
    parameter int NOPS = 4,
    localparam int HW  = DW / 2
) (
    input  logic [DW-1:0] ops     [NOPS],
    input  logic          ops_vld [NOPS],
    input  logic [DW-1:0] first,
    input  logic [DW-1:0] second,
    input  logic [DW-1:0] result,
    input  logic          is_add,
    output logic          ca,
    output logic          ca32
);
    logic [NOPS-1:0] gt_full;
    logic [NOPS-1:0] gt_low;

    // Unsigned magnitude tests per operand slot
    for (genvar i = 0; i < NOPS; i++) begin : g_cmp
        assign gt_full[i] = ops_vld[i] && (ops[i] > result);
        assign gt_low[i]  = ops_vld[i] && (ops[i][HW-1:0] > result[HW-1:0]);
    end

    assign ca   = |gt_full;
    assign ca32 = is_add ? (result[HW] ^ first[HW] ^ second[HW]) : |gt_low;

endmodule

// File: rtl/fxflag_ovf.sv
module fxflag_ovf #(
    parameter int DW  = 64,
    localparam int HW = DW / 2
) (
    input  logic [DW-1:0] first,
    input  logic [DW-1:0] second,
    input  logic [DW-1:0] result,
    input  logic          n_ge2,
    input  logic          div_vld,
    input  logic          div_ov,
    output logic          upd,
    output logic          ov,
    output logic          ov32
);
    logic ov_arith;
    logic ov32_arith;

    assign ov_arith   = (first[DW-1] == second[DW-1]) && (result[DW-1] != first[DW-1]);
    assign ov32_arith = (first[HW-1] == second[HW-1]) && (result[HW-1] != first[HW-1]);

    always_comb begin
        upd  = 1'b0;
        ov   = 1'b0;
        ov32 = 1'b0;
        if (div_vld) begin
            upd  = 1'b1;
            ov   = div_ov;
            ov32 = div_ov;
        end else if (n_ge2) begin
            upd  = 1'b1;
            ov   = ov_arith;
            ov32 = ov32_arith;
        end
    end

endmodule

// File: rtl/fx_flag_unit.sv
module fx_flag_unit
    import fxflag_pkg::*;
#(
    parameter int DW   = 64,
    parameter int NREG = 3
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         valid,
    input  logic [DW-1:0]                op_a,
    input  logic [DW-1:0]                op_b,
    input  logic [DW-1:0]                op_c,
    input  logic [$clog2(NREG+1)-1:0]    num_ops,
    input  logic [DW-1:0]                imm,
    input  logic                         imm_vld,
    input  logic                         inv_a,
    input  logic [DW-1:0]                result,
    input  logic                         is_add,
    input  logic                         carry_en,
    input  logic                         ov_en,
    input  logic                         rc_en,
    input  logic [1:0]                   done_mask,
    input  logic                         div_ov_vld,
    input  logic                         div_ov,
    output logic                         ca,
    output logic                         ca32,
    output logic                         ov,
    output logic                         ov32,
    output logic                         so,
    output logic [3:0]                   cr0
);
    localparam int NOPS = NREG + 1;

    logic [DW-1:0] regs    [NREG];
    logic [DW-1:0] ops     [NOPS];
    logic          ops_vld [NOPS];
    logic [DW-1:0] first, second;
    logic          n_ge2;
    logic          c_full, c_low;
    logic          o_upd, o_full, o_low;

    xer_bits_t cur_q, nxt;
    logic [3:0] cr_q, cr_nxt;

    assign regs[0] = op_a;
    assign regs[1] = op_b;
    assign regs[2] = op_c;

    fxflag_opsel #(.DW(DW), .NREG(NREG)) u_opsel (
        .regs      (regs),
        .num_ops   (num_ops),
        .imm       (imm),
        .imm_vld   (imm_vld),
        .inv_first (inv_a),
        .ops       (ops),
        .ops_vld   (ops_vld),
        .first     (first),
        .second    (second),
        .n_ge2     (n_ge2)
    );

    fxflag_carry #(.DW(DW), .NOPS(NOPS)) u_carry (
        .ops     (ops),
        .ops_vld (ops_vld),
        .first   (first),
        .second  (second),
        .result  (result),
        .is_add  (is_add),
        .ca      (c_full),
        .ca32    (c_low)
    );

    fxflag_ovf #(.DW(DW)) u_ovf (
        .first   (first),
        .second  (second),
        .result  (result),
        .n_ge2   (n_ge2),
        .div_vld (div_ov_vld),
        .div_ov  (div_ov),
        .upd     (o_upd),
        .ov      (o_full),
        .ov32    (o_low)
    );

    // Next-value selection per flag group
    always_comb begin
        nxt    = cur_q;
        cr_nxt = cr_q;
        if (carry_en) begin
            if (!done_mask[0]) nxt.ca   = c_full;
            if (!done_mask[1]) nxt.ca32 = c_low;
        end
        if (ov_en && o_upd) begin
            nxt.ov   = o_full;
            nxt.ov32 = o_low;
            nxt.so   = cur_q.so | o_full;
        end
        if (rc_en) begin
            cr_nxt[CR_NEG]  = result[DW-1];
            cr_nxt[CR_POS]  = !result[DW-1] && (result != '0);
            cr_nxt[CR_ZERO] = (result == '0);
            cr_nxt[CR_SO]   = nxt.so;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q <= '0;
            cr_q  <= '0;
        end else if (valid) begin
            cur_q <= nxt;
            cr_q  <= cr_nxt;
        end
    end

    assign ca   = cur_q.ca;
    assign ca32 = cur_q.ca32;
    assign ov   = cur_q.ov;
    assign ov32 = cur_q.ov32;
    assign so   = cur_q.so;
    assign cr0  = cr_q;

endmodule

// File: rtl/fx_flag_unit_chk.sv
module fx_flag_unit_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       valid,
    input logic       carry_en,
    input logic       ov_en,
    input logic       rc_en,
    input logic [1:0] done_mask,
    input logic       div_ov_vld,
    input logic       div_ov,
    input logic       ca,
    input logic       ca32,
    input logic       ov,
    input logic       ov32,
    input logic       so,
    input logic [3:0] cr0
);
    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !valid |=> $stable({ca, ca32, ov, ov32, so, cr0}));

    p_carry_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && !carry_en) |=> $stable({ca, ca32}));

    p_rec_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && !rc_en) |=> $stable(cr0));

    p_mask_ca_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && done_mask[0]) |=> $stable(ca));

    p_mask_ca32_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && done_mask[1]) |=> $stable(ca32));

    p_div_copy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && ov_en && div_ov_vld) |=> (ov == $past(div_ov)) && (ov32 == $past(div_ov)));

    p_so_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        so |=> so);

    p_cr_shape_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && rc_en) |=> (cr0[0] == so) && ($countones(cr0[3:1]) == 1));

endmodule

bind fx_flag_unit fx_flag_unit_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .valid      (valid),
    .carry_en   (carry_en),
    .ov_en      (ov_en),
    .rc_en      (rc_en),
    .done_mask  (done_mask),
    .div_ov_vld (div_ov_vld),
    .div_ov     (div_ov),
    .ca         (ca),
    .ca32       (ca32),
    .ov         (ov),
    .ov32       (ov32),
    .so         (so),
    .cr0        (cr0)
);

// File: tb/fx_flag_unit_bench.sv
`timescale 1ns/1ps
module fx_flag_unit_bench;

    typedef struct packed {
        logic [63:0] a, b, c, res, imm;
        logic [1:0]  nops;
        logic        immv, inv, add, cen, oen, ren;
        logic [1:0]  mask;
        logic        dvv, dv;
        logic [8:0]  exp;   // {ca, ca32, ov, ov32, so, cr0[3:0]}
    } vec_t;

    localparam int NV = 15;
    localparam vec_t TBL [NV] = '{
        '{64'h5, 64'h3, 64'h0, 64'h8, 64'h0, 2'd2, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 2'b00, 1'b0, 1'b0, 9'b00000_0100},
        '{64'hFFFF_FFFF_FFFF_FFFF, 64'h2, 64'h0, 64'h1, 64'h0, 2'd2, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 2'b00, 1'b0, 1'b0, 9'b11000_0100},
        '{64'h7FFF_FFFF_FFFF_FFFF, 64'h1, 64'h0, 64'h8000_0000_0000_0000, 64'h0, 2'd2, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 2'b00, 1'b0, 1'b0, 9'b01101_1001},
        '{64'h1_0000_0005, 64'h9, 64'h0, 64'h1_0000_0003, 64'h0, 2'd2, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 2'b00, 1'b0, 1'b0, 9'b11101_1001},
        '{64'h2_0000_0001, 64'h0, 64'h0, 64'h3_0000_0000, 64'h0, 2'd2, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 2'b00, 1'b0, 1'b0, 9'b01101_1001},
        '{64'hFFFF_FFFF_FFFF_FFFF, 64'h2, 64'h0, 64'h1, 64'h0, 2'd2, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 2'b01, 1'b0, 1'b0, 9'b01101_1001},
        '{64'h1_0000_0000, 64'h0, 64'h0, 64'h5, 64'h0, 2'd2, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 2'b10, 1'b0, 1'b0, 9'b11101_1001},
        '{64'hFFFF_FFFF_FFFF_FFF0, 64'h0, 64'h0, 64'h1F, 64'h10, 2'd1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 2'b00, 1'b0, 1'b0, 9'b00001_0101},
        '{64'h7FFF_FFFF_FFFF_FFFF, 64'h0, 64'h0, 64'h8000_0000_0000_0000, 64'h0, 2'd1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 2'b00, 1'b0, 1'b0, 9'b00001_0101},
        '{64'hA, 64'h0, 64'h0, 64'h0, 64'h0, 2'd2, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 2'b00, 1'b1, 1'b1, 9'b00111_0011},
        '{64'h0, 64'h0, 64'h0, 64'h0, 64'h0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 2'b00, 1'b1, 1'b0, 9'b00001_0011},
        '{64'h7FFF_FFFF, 64'h1, 64'h0, 64'h8000_0000, 64'h0, 2'd2, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 2'b00, 1'b0, 1'b0, 9'b00011_0011},
        '{64'h1, 64'h2, 64'hFFFF_FFFF_0000_0000, 64'h10, 64'h0, 2'd3, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 2'b00, 1'b0, 1'b0, 9'b10011_0011},
        '{64'h1, 64'h2, 64'hFFFF_FFFF_0000_0000, 64'h10, 64'h0, 2'd2, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 2'b00, 1'b0, 1'b0, 9'b00011_0011},
        '{64'h1_0000_0000, 64'h0, 64'h0, 64'h1, 64'h0, 2'd1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 2'b00, 1'b0, 1'b0, 9'b11011_0011}
    };

    function automatic string tag_of(int i);
        case (i)
            0:       return "R4 R11";
            1, 14:   return "R5";
            2:       return "R8 R11";
            3, 4:    return "R6";
            5, 6:    return "R7";
            7:       return "R3 R11";
            8, 11:   return "R8";
            9:       return "R9 R11";
            10:      return "R10";
            default: return "R3";
        endcase
    endfunction

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        valid = 1'b0;
    logic [63:0] op_a = '0, op_b = '0, op_c = '0, imm = '0, result = '0;
    logic [1:0]  num_ops = '0, done_mask = '0;
    logic        imm_vld = 0, inv_a = 0, is_add = 0, carry_en = 0, ov_en = 0, rc_en = 0;
    logic        div_ov_vld = 0, div_ov = 0;
    logic        ca, ca32, ov, ov32, so;
    logic [3:0]  cr0;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    fx_flag_unit u_fx_flag_unit (
        .clk(clk), .rst_n(rst_n), .valid(valid),
        .op_a(op_a), .op_b(op_b), .op_c(op_c), .num_ops(num_ops),
        .imm(imm), .imm_vld(imm_vld), .inv_a(inv_a), .result(result),
        .is_add(is_add), .carry_en(carry_en), .ov_en(ov_en), .rc_en(rc_en),
        .done_mask(done_mask), .div_ov_vld(div_ov_vld), .div_ov(div_ov),
        .ca(ca), .ca32(ca32), .ov(ov), .ov32(ov32), .so(so), .cr0(cr0)
    );

    task automatic check(input string req, input logic [8:0] exp);
        logic [8:0] act;
        act = {ca, ca32, ov, ov32, so, cr0};
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: flags actual %b expected %b", req, act, exp);
        end
    endtask

    task automatic drive(input vec_t v, input logic vld);
        op_a = v.a; op_b = v.b; op_c = v.c; result = v.res; imm = v.imm;
        num_ops = v.nops; imm_vld = v.immv; inv_a = v.inv; is_add = v.add;
        carry_en = v.cen; ov_en = v.oen; rc_en = v.ren; done_mask = v.mask;
        div_ov_vld = v.dvv; div_ov = v.dv; valid = vld;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog: run did not complete");
        finish_run();
    end

    initial begin
        vec_t busy;
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 reset", 9'b0);
        rst_n = 1'b1;

        // Vector table walk: one update per entry
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            drive(TBL[i], 1'b1);
            @(negedge clk);
            valid = 1'b0;
            check(tag_of(i), TBL[i].exp);
        end

        // R2: strobe low, all enables set with changing operands -> hold
        busy = TBL[2];
        busy.mask = 2'b00;
        @(negedge clk);
        drive(busy, 1'b0);
        @(negedge clk);
        check("R2 no strobe", 9'b11011_0011);

        // R2: strobe high but every group disabled -> hold
        busy.cen = 0; busy.oen = 0; busy.ren = 0;
        drive(busy, 1'b1);
        @(negedge clk);
        valid = 1'b0;
        check("R2 groups disabled", 9'b11011_0011);

        // R10: sticky so survives a clean overflow update
        busy = TBL[0];
        drive(busy, 1'b1);
        @(negedge clk);
        valid = 1'b0;
        check("R10 sticky", 9'b00001_0101);

        // R1: reset mid-run clears so and cr0
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 mid-run reset", 9'b0);
        rst_n = 1'b1;

        // R11: negative result from reset, so stays 0
        busy = TBL[0];
        busy.res = 64'hFFFF_FFFF_FFFF_FFFE;
        busy.oen = 0; busy.cen = 0;
        drive(busy, 1'b1);
        @(negedge clk);
        valid = 1'b0;
        check("R11 negative", 9'b00000_1000);

        finish_run();
    end

endmodule